// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter built from a chain of four-bit stages. Each stage counts modulo 16. Stage i only counts when the stage below it is at fifteen and the chain's trickle enable is high. The carry therefore ripples as a combinational enable, and every stage switches on the same rising clock edge. A shared parallel enable can freeze the whole chain. A shared active-low load writes a preset word on the next edge. An active-low clear empties the counter at once, without a clock.

The terminal-count output is high only when the whole count is all ones and the trickle enable is high. A wider chain can therefore take it as its own trickle enable. Feed the inverted terminal count back into the load input and the chain becomes a programmable divider. It reloads a preset after each all-ones state and pulses terminal count once every 2^W − preset clocks.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only on a rising clock edge. Input changes between edges leave `q` unchanged.
- R2: While `clr_n` is low, `q` is zero at once, without waiting for a clock edge. This also holds while `load_n` is low and the enables are high.
- R3: With `clr_n` high and `load_n` low, the next rising edge copies `din` into `q`, whatever `en_p` and `en_t` are.
- R4: With `load_n`, `en_p` and `en_t` all high, `q` increases by one per rising edge, and all-ones wraps to zero.
- R5: With `load_n` high and `en_p` low, `q` holds.
- R6: With `load_n` high and `en_t` low, `q` holds.
- R7: `tc` is high exactly when `en_t` is high and `q` is all ones. It is therefore low while the clear is active.
- R8: When the low nibble is 15 and the chain counts, the next nibble up takes the carry on the same edge. For example, 0x0F becomes 0x10.
- R9: With `load_n` driven by the inverse of `tc` and both enables high, `tc` pulses once every 2^W − `din` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, shared by all stages |
| en_t | input | 1 | Trickle count enable into the lowest stage |
| din | input | 4*STAGES | Preset value for a load |
| q | output | 4*STAGES | Counter state, stage 0 in the lowest nibble |
| tc | output | 1 | Terminal count: `en_t` high and `q` all ones |

## Verification
Random mixes of load, the two enables and preset words are checked against a bench model. Each cycle is classed as load, count or a hold caused by one particular enable, which separates a bad priority from a bad enable decode. Directed cases preset 0x0F, 0xFF and 0xFE to exercise the nibble carry, the full wrap and the trickle gating of `tc`. A clear asserted between edges and released just before an edge shows whether the clear is asynchronous and overrides a pending load. Divider runs with several presets measure the gap between `tc` pulses.

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int STAGES = 2,
  localparam int W = 4 * STAGES
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);

  logic [STAGES:0] carry;
  assign carry[0] = en_t;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [3:0] nib;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                nib <= 4'd0;
      else if (!load_n)          nib <= din[4*g +: 4];
      else if (en_p && carry[g]) nib <= nib + 4'd1;
    end
    assign carry[g+1]   = carry[g] & (&nib);
    assign q[4*g +: 4]  = nib;
  end

  assign tc = carry[STAGES];

  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == $past(q) + W'(1));

  a_r5_hold_par: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !en_p) |=> $stable(q));

  a_r6_hold_trk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !en_t) |=> $stable(q));

  a_r7_term: assert property (@(posedge clk) disable iff (!clr_n)
    tc == (en_t && q == {W{1'b1}}));

endmodule

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
  localparam int STAGES = 2;
  localparam int W = 4 * STAGES;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic clr_n = 1'b0, ld = 1'b1, en_p = 1'b0, en_t = 1'b0, div = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic tc, load_n;
  logic [W-1:0] m;
  string tag;
  int checks = 0, errors = 0;

  assign load_n = div ? ~tc : ld;

  always #4 clk = ~clk;

  presettable_counter #(.STAGES(STAGES)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q), .tc(tc));

  function automatic logic [W-1:0] nxt(logic [W-1:0] s, logic l_n, logic p, logic t,
                                       logic [W-1:0] d);
    if (!l_n) return d;
    if (p && t) return s + W'(1);
    return s;
  endfunction

  function automatic string cls(logic l_n, logic p, logic t);
    if (!l_n) return "R3";
    if (!p) return "R5";
    if (!t) return "R6";
    return "R4";
  endfunction

  task automatic chk(string r, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic check_state();
    chk(tag, q, m);
    chk("R7", W'(tc), W'(en_t && m == ONES));
  endtask

  task automatic drive(logic l_n, logic p, logic t, logic [W-1:0] d);
    ld = l_n; en_p = p; en_t = t; din = d;
    tag = cls(l_n, p, t);
    m = nxt(m, l_n, p, t, d);
  endtask

  task automatic cycle(logic l_n, logic p, logic t, logic [W-1:0] d);
    drive(l_n, p, t, d);
    @(negedge clk);
    check_state();
  endtask

  task automatic divider(logic [W-1:0] pre);
    int first, second, third, n;
    cycle(1'b0, 1'b1, 1'b1, pre);
    div = 1'b1;
    first = -1; second = -1; third = -1; n = 0;
    while (third < 0 && n < 4 * (1 << W) + 8) begin
      @(negedge clk);
      n++;
      if (tc) begin
        if (first < 0) first = n;
        else if (second < 0) second = n;
        else third = n;
      end
    end
    chk("R9", W'(second - first), W'((1 << W) - int'(pre)));
    chk("R9", W'(third - second), W'((1 << W) - int'(pre)));
    div = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m = '0;
    tag = "R2";
    en_t = 1'b1;
    @(negedge clk);
    chk("R2", q, '0);
    chk("R7", W'(tc), '0);
    clr_n = 1'b1;

    // R1: input changes between edges do not move q
    drive(1'b0, 1'b1, 1'b1, 8'h5A);
    #2 chk("R1", q, '0);
    @(negedge clk);
    check_state();

    // R8 carry across nibble boundary
    cycle(1'b0, 1'b0, 1'b0, 8'h0F);
    cycle(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R8", q, 8'h10);
    // R4 full wrap, R7 gating by trickle enable
    cycle(1'b0, 1'b1, 1'b1, ONES);
    drive(1'b1, 1'b1, 1'b0, 8'h00);
    #1 chk("R7", W'(tc), '0);
    @(negedge clk);
    check_state();
    cycle(1'b1, 1'b0, 1'b1, 8'h00);
    chk("R5", q, ONES);
    cycle(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R4", q, 8'h00);
    cycle(1'b0, 1'b1, 1'b1, 8'hFE);
    cycle(1'b1, 1'b1, 1'b1, 8'h00);

    // R2: clear mid-cycle overrides pending load, released near an edge
    drive(1'b0, 1'b1, 1'b1, 8'hAA);
    @(posedge clk);
    #2 clr_n = 1'b0;
    #1 chk("R2", q, '0);
    chk("R7", W'(tc), '0);
    @(posedge clk);
    #2 chk("R2", q, '0);
    @(negedge clk);
    m = '0;
    drive(1'b1, 1'b1, 1'b1, 8'h00);
    #3 clr_n = 1'b1;
    @(negedge clk);
    check_state();
    chk("R4", q, 8'h01);

    for (int i = 0; i < 400; i++) begin
      logic l_n, p, t;
      logic [W-1:0] d;
      l_n = ($urandom % 8) != 0;
      p   = ($urandom % 4) != 0;
      t   = ($urandom % 4) != 0;
      d   = W'($urandom);
      if (($urandom % 16) == 0) d = ONES - W'($urandom % 3);
      cycle(l_n, p, t, d);
    end

    divider(8'd0);
    divider(8'd200);
    divider(8'd128);
    divider(8'd254);
    divider(8'd255);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule